// File: doc/BRIEF.md
# Host Controller Interrupt Register Block

This block keeps the interrupt state of a USB host controller. The controller core gives it one-cycle event pulses: the done queue was written back, a frame scheduling overrun happened, the root hub status changed, and four further sources. Each pulse sets a sticky status bit. Software clears a status bit by writing a one to it.

Each source has its own enable bit, and a master enable gates all of them. The block drives one level-sensitive interrupt line to an external interrupt controller. That line stays high while any enabled status bit is set and the master enable is on.

Enable bits are set through one register address and cleared through a second one. Software can therefore change single enables without a read-modify-write sequence. Access uses a plain 32-bit port with a word address, a write strobe, write data and combinational read data.

Top module: `hc_irq_regs`

## Requirements
- R1: After reset, every word (0 status, 1 enable set, 2 enable clear, 3 unused) reads 0 and `irq_o` is low.
- R2: A pulse on `evt_i[k]` sets status bit k. Source bit 0 is scheduling overrun, bit 1 is done-head written, bit 6 is root hub change, and bits 2 to 5 are other sources. The bit reads 1 from the next cycle and stays set until software clears it.
- R3: Writing word 0 clears each status bit whose data bit is 1 and leaves each status bit whose data bit is 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Writing word 1 sets each enable bit whose data bit is 1 and leaves the others unchanged. Bits 0 to 6 are the per-source enables, bit 30 is the ownership bit and bit 31 is the master enable.
- R6: Writing word 2 clears each enable bit whose data bit is 1 and ignores zeros. Words 1 and 2 both read the current enable value.
- R7: `irq_o` is high exactly when the master enable is 1 and some status bit k in 0..6 has its enable bit k set. With the master enable at 0, `irq_o` stays low.
- R8: Enable bit 30 can be set and cleared and reads back, but it never affects `irq_o`.
- R9: Status bits 31..7 and enable bits 29..7 always read 0, and writes to them have no effect. Word 3 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | One-cycle event pulses from the controller core, one per source |
| reg_addr | input | 2 | Word address: 0 status, 1 enable set, 2 enable clear |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
Some properties are checked on every cycle by the assertions:
- an event always leaves its status bit set, even under a clearing write;
- a status write with no event removes exactly the written ones;
- enable bits drop only through the clear address;
- the line stays low without the master enable;
- reserved read bits stay zero.

Other behaviour only the bench scenarios can show. These are the exact read values at each address, the ownership bit having no effect on the line, and the line following the root hub source as its enable and the master enable are toggled.

// File: rtl/hc_irq_regs.sv
module hc_irq_regs #(
  parameter int NSRC    = 7,
  parameter int DW      = 32,
  parameter int MIE_BIT = 31,
  parameter int OWN_BIT = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [1:0]      reg_addr,
  input  logic            reg_we,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_o
);
  localparam logic [1:0] A_STS = 2'd0;
  localparam logic [1:0] A_SET = 2'd1;
  localparam logic [1:0] A_CLR = 2'd2;

  logic [NSRC-1:0] sts_q, en_q;
  logic            mie_q, own_q;
  logic            wr_sts, wr_set, wr_clr;
  logic [DW-1:0]   en_word;

  assign wr_sts = reg_we && (reg_addr == A_STS);
  assign wr_set = reg_we && (reg_addr == A_SET);
  assign wr_clr = reg_we && (reg_addr == A_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      mie_q <= 1'b0;
      own_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~(wr_sts ? reg_wdata[NSRC-1:0] : '0)) | evt_i;
      if (wr_set) begin
        en_q  <= en_q | reg_wdata[NSRC-1:0];
        mie_q <= mie_q | reg_wdata[MIE_BIT];
        own_q <= own_q | reg_wdata[OWN_BIT];
      end else if (wr_clr) begin
        en_q  <= en_q & ~reg_wdata[NSRC-1:0];
        mie_q <= mie_q & ~reg_wdata[MIE_BIT];
        own_q <= own_q & ~reg_wdata[OWN_BIT];
      end
    end
  end

  always_comb begin
    en_word          = '0;
    en_word[NSRC-1:0] = en_q;
    en_word[MIE_BIT] = mie_q;
    en_word[OWN_BIT] = own_q;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STS:        reg_rdata[NSRC-1:0] = sts_q;
      A_SET, A_CLR: reg_rdata = en_word;
      default:      reg_rdata = '0;
    endcase
  end

  assign irq_o = mie_q & |(sts_q & en_q);

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i))); // R4
  AST_W1C_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && evt_i == '0) |=> (sts_q == ($past(sts_q) & ~$past(reg_wdata[NSRC-1:0])))); // R3
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((en_q & $past(en_q)) == $past(en_q))); // R5
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !mie_q |-> !irq_o); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[OWN_BIT-1:NSRC] == '0); // R9
endmodule

// File: tb/hc_irq_regs_bench.sv
`timescale 1ns/1ps
module hc_irq_regs_bench;
  typedef struct {
    logic [31:0] rd;
    logic        irq;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0, reg_we = 0, irq_o;
  logic [6:0]  evt_i = '0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  exp_t        sb[$];
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  hc_irq_regs u_hc_irq_regs (.clk, .rst_n, .evt_i, .reg_addr, .reg_we,
                             .reg_wdata, .reg_rdata, .irq_o);

  task automatic drive(input logic [6:0] ev, input logic we,
                       input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    evt_i = ev; reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    evt_i = '0; reg_we = 0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    drive('0, 1'b1, a, d);
  endtask

  task automatic chk(input logic [1:0] a, input logic [31:0] rd,
                     input logic irq, input string tag);
    exp_t e;
    @(negedge clk);
    reg_addr = a;
    e.rd = rd; e.irq = irq; e.tag = tag;
    sb.push_back(e);
    #2;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_run++;
        if (reg_rdata !== e.rd || irq_o !== e.irq) begin
          n_fail++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   e.tag, reg_rdata, irq_o, e.rd, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(2'd0, 32'h0, 0, "R1 status");
    chk(2'd1, 32'h0, 0, "R1 enable");
    chk(2'd2, 32'h0, 0, "R1 clear word");
    chk(2'd3, 32'h0, 0, "R1 unused");
    drive(7'h02, 0, 2'd0, '0);
    chk(2'd0, 32'h2, 0, "R2 done-head set");
    drive(7'h01, 0, 2'd0, '0);
    chk(2'd0, 32'h3, 0, "R2 overrun accumulates");
    wr(2'd0, 32'h0);
    chk(2'd0, 32'h3, 0, "R3 zero write ignored");
    wr(2'd0, 32'h2);
    chk(2'd0, 32'h1, 0, "R3 one clears");
    wr(2'd0, 32'hFFFF_FF80);
    chk(2'd0, 32'h1, 0, "R9 reserved status");
    wr(2'd1, 32'h1);
    chk(2'd1, 32'h1, 0, "R5 enable set, R7 no master");
    wr(2'd1, 32'h0);
    chk(2'd1, 32'h1, 0, "R5 zero ignored");
    wr(2'd1, 32'h8000_0000);
    chk(2'd1, 32'h8000_0001, 1, "R7 master on");
    chk(2'd2, 32'h8000_0001, 1, "R6 clear word reads enable");
    wr(2'd0, 32'h1);
    chk(2'd0, 32'h0, 0, "R7 cleared status drops irq");
    drive(7'h01, 1, 2'd0, 32'h1);
    chk(2'd0, 32'h1, 1, "R4 set wins");
    wr(2'd2, 32'h1);
    chk(2'd1, 32'h8000_0000, 0, "R6 clear enable bit");
    wr(2'd2, 32'h0);
    chk(2'd1, 32'h8000_0000, 0, "R6 zero ignored");
    wr(2'd1, 32'h4000_0000);
    chk(2'd1, 32'hC000_0000, 0, "R8 ownership no effect");
    wr(2'd1, 32'h3FFF_FF80);
    chk(2'd1, 32'hC000_0000, 0, "R9 reserved enable");
    chk(2'd3, 32'h0, 0, "R9 unused word");
    drive(7'h40, 0, 2'd0, '0);
    chk(2'd0, 32'h41, 0, "R2 root hub set");
    wr(2'd1, 32'h40);
    chk(2'd1, 32'hC000_0040, 1, "R7 root hub enabled");
    wr(2'd2, 32'h8000_0000);
    chk(2'd1, 32'h4000_0040, 0, "R7 master cleared");
    wr(2'd2, 32'h4000_0000);
    chk(2'd1, 32'h0000_0040, 0, "R8 ownership clears");
    wr(2'd1, 32'h8000_0000);
    chk(2'd0, 32'h41, 1, "R7 master restored");
    wr(2'd0, 32'h40);
    chk(2'd0, 32'h01, 0, "R3 root hub cleared");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule